// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the host's write cycles to a word-wide non-volatile memory. It picks out fixed multi-cycle unlock commands from the ordinary traffic. Some commands are six cycles long and use full-width codes, in which both bytes of the data word are equal. Others are three cycles long and use byte-wide codes, zero-extended. All of them open with the same address pair. The decoder turns a completed command into one of these actions: setting or clearing a software write-protect flag, starting a self-timed chip erase, or entering or leaving an identification mode. It also decides whether a plain write counts as page data for the downstream page loader.

The write-protect flag models a non-volatile bit. It has its own initialisation input, which sets it, and the ordinary reset leaves it unchanged. While the flag is set, page data is accepted only inside a page window. That window opens when the three-cycle protected-write command completes and closes when the page loader reports the end of the page. While the identification mode is active, reads of word 0 and word 1 return fixed manufacturer and device codes. The array programming and erase timing are outside this block. An external busy input stops new sequences from starting while such an operation runs.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Command matching compares only address bits [14:0]. With the default 16-bit address, bit 15 has no effect on whether a command step matches.
- R2: The sequence 5555h←AAAAh, 2AAAh←5555h, 5555h←A0A0h sets the protect flag and opens the page window. While the window is open, every write is page data: dataWrOk pulses and no decoding happens. A pageDone pulse closes the window.
- R3: With the protect flag set and the window closed, a write that does not belong to a command gives no dataWrOk. With the flag clear, such a write gives a dataWrOk pulse one cycle later.
- R4: The six-cycle sequence 5555h←AAAAh, 2AAAh←5555h, 5555h←8080h, 5555h←AAAAh, 2AAAh←5555h, 5555h←2020h clears the protect flag.
- R5: The same first five cycles followed by 5555h←1010h give a single-cycle eraseStart pulse and leave the protect flag unchanged.
- R6: Identification mode is entered by either of two sequences: the same first five cycles followed by 5555h←6060h, or the three byte-wide cycles 5555h←00AAh, 2AAAh←0055h, 5555h←0090h. It is left by 5555h←00AAh, 2AAAh←0055h, 5555h←00F0h.
- R7: In identification mode, rdAddr 0 gives idHit=1 with idData=00DAh, and rdAddr 1 gives idHit=1 with idData=004Fh. Any other address, or any address outside the mode, gives idHit=0 and idData=0.
- R8: A write that is not the expected next step aborts the sequence and is then checked again as a possible first step. A full-width sequence does not accept a byte-wide code, and a code with any single data bit flipped does not match.
- R9: Each completed command gives a cmdDone pulse of exactly one cycle, in the cycle after its final write.
- R10: While busy is high, a write seen by the idle decoder neither starts a sequence nor counts as page data. A sequence already in progress still completes.
- R11: Only nvInitN sets the protect flag, and rstN does not change it. rstN clears identification mode, the page window and the sequence state.
- R12: After reset the pulse outputs are low, idMode and pageWin are low, and protectOn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the decoder state |
| nvInitN | input | 1 | Active-low initialisation of the persistent protect flag (sets it) |
| wrValid | input | 1 | Host write cycle present this clock |
| wrAddr | input | 16 | Host write word address |
| wrData | input | 16 | Host write data |
| busy | input | 1 | An erase or program operation is running |
| pageDone | input | 1 | Page loader has finished the current page |
| rdAddr | input | 16 | Host read word address |
| protectOn | output | 1 | Software write-protect flag |
| pageWin | output | 1 | Page-load window open |
| idMode | output | 1 | Identification mode active |
| dataWrOk | output | 1 | Pulse: previous write accepted as page data |
| eraseStart | output | 1 | Pulse: start chip erase |
| cmdDone | output | 1 | Pulse: a command sequence completed |
| idHit | output | 1 | Read address hits an identification word |
| idData | output | 16 | Identification word for rdAddr |

## Verification
The bench builds the block with its default parameters: a 16-bit host address of which 15 bits are compared, and 16-bit data. With these values it can sweep every address bit of a final command step, including the ignored top bit, and every data bit of a final code word, each flip expected to abort. It also reads a range of identification addresses in and out of the mode, and walks the protect flag through set, clear and reset to show which reset touches it.

// File: rtl/usd_pkg.sv
package usd_pkg;

  typedef struct packed {
    logic startFull;
    logic startByte;
    logic secFull;
    logic secByte;
    logic cProt;
    logic cMore;
    logic cUnprot;
    logic cErase;
    logic cIdLong;
    logic cIdShort;
    logic cIdExit;
  } cmdMatchT;

  typedef struct packed {
    logic setProt;
    logic clrProt;
    logic idOn;
    logic idOff;
    logic erase;
    logic openWin;
    logic dataOk;
    logic done;
  } ctrlStrobeT;

  typedef enum logic [2:0] {
    S_IDLE,
    S_F1,
    S_F2,
    S_F3,
    S_F4,
    S_F5,
    S_B1,
    S_B2
  } seqStateT;

  localparam logic [7:0] B_UNLK1 = 8'hAA;
  localparam logic [7:0] B_UNLK2 = 8'h55;
  localparam logic [7:0] B_PROT  = 8'hA0;
  localparam logic [7:0] B_MORE  = 8'h80;
  localparam logic [7:0] B_UNPR  = 8'h20;
  localparam logic [7:0] B_ERASE = 8'h10;
  localparam logic [7:0] B_IDLNG = 8'h60;
  localparam logic [7:0] B_IDSHT = 8'h90;
  localparam logic [7:0] B_IDEXT = 8'hF0;

endpackage

// File: rtl/usd_match.sv
module usd_match
  import usd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMP_W  = 15,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output cmdMatchT          match
);

  localparam int REP = DATA_W / 8;
  localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'({CMP_W{1'b1}});
  localparam logic [ADDR_W-1:0] A_ONE    = ADDR_W'(32'h5555) & CMP_MASK;
  localparam logic [ADDR_W-1:0] A_TWO    = ADDR_W'(32'h2AAA) & CMP_MASK;

  localparam int NCODE = 9;
  localparam logic [7:0] CODE_BYTES [NCODE] = '{
    B_UNLK1, B_UNLK2, B_PROT, B_MORE, B_UNPR, B_ERASE, B_IDLNG, B_IDSHT, B_IDEXT
  };

  logic [NCODE-1:0] fullHit;
  logic [NCODE-1:0] byteHit;
  logic             atOne;
  logic             atTwo;

  assign atOne = (addr & CMP_MASK) == A_ONE;
  assign atTwo = (addr & CMP_MASK) == A_TWO;

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    assign fullHit[i] = data == {REP{CODE_BYTES[i]}};
    assign byteHit[i] = data == DATA_W'(CODE_BYTES[i]);
  end

  always_comb begin
    match           = '0;
    match.startFull = atOne && fullHit[0];
    match.startByte = atOne && byteHit[0];
    match.secFull   = atTwo && fullHit[1];
    match.secByte   = atTwo && byteHit[1];
    match.cProt     = atOne && fullHit[2];
    match.cMore     = atOne && fullHit[3];
    match.cUnprot   = atOne && fullHit[4];
    match.cErase    = atOne && fullHit[5];
    match.cIdLong   = atOne && fullHit[6];
    match.cIdShort  = atOne && byteHit[7];
    match.cIdExit   = atOne && byteHit[8];
  end

endmodule

// File: rtl/usd_ctrl.sv
module usd_ctrl
  import usd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       busy,
  input  logic       winOpen,
  input  logic       protOn,
  input  cmdMatchT   match,
  output ctrlStrobeT strb
);

  seqStateT state;
  seqStateT nextState;
  logic     advance;

  always_comb begin
    nextState = state;
    strb      = '0;
    advance   = 1'b0;
    if (wrValid) begin
      if (winOpen) begin
        strb.dataOk = 1'b1;
      end else begin
        unique case (state)
          S_F1: if (match.secFull) begin
            nextState = S_F2;
            advance   = 1'b1;
          end
          S_F2: if (match.cProt) begin
            nextState    = S_IDLE;
            strb.setProt = 1'b1;
            strb.openWin = 1'b1;
            strb.done    = 1'b1;
            advance      = 1'b1;
          end else if (match.cMore) begin
            nextState = S_F3;
            advance   = 1'b1;
          end
          S_F3: if (match.startFull) begin
            nextState = S_F4;
            advance   = 1'b1;
          end
          S_F4: if (match.secFull) begin
            nextState = S_F5;
            advance   = 1'b1;
          end
          S_F5: if (match.cUnprot) begin
            nextState    = S_IDLE;
            strb.clrProt = 1'b1;
            strb.done    = 1'b1;
            advance      = 1'b1;
          end else if (match.cErase) begin
            nextState  = S_IDLE;
            strb.erase = 1'b1;
            strb.done  = 1'b1;
            advance    = 1'b1;
          end else if (match.cIdLong) begin
            nextState = S_IDLE;
            strb.idOn = 1'b1;
            strb.done = 1'b1;
            advance   = 1'b1;
          end
          S_B1: if (match.secByte) begin
            nextState = S_B2;
            advance   = 1'b1;
          end
          S_B2: if (match.cIdShort) begin
            nextState = S_IDLE;
            strb.idOn = 1'b1;
            strb.done = 1'b1;
            advance   = 1'b1;
          end else if (match.cIdExit) begin
            nextState  = S_IDLE;
            strb.idOff = 1'b1;
            strb.done  = 1'b1;
            advance    = 1'b1;
          end
          default: ;
        endcase
        if (!advance) begin
          if (!busy && match.startFull) begin
            nextState = S_F1;
          end else if (!busy && match.startByte) begin
            nextState = S_B1;
          end else begin
            nextState   = S_IDLE;
            strb.dataOk = !protOn && !busy;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R10: an idle write under busy leaves the decoder idle
  a_r10_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && wrValid && busy && !winOpen) |=> state == S_IDLE);

  // R9: at most one command action per cycle
  a_r9_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setProt, strb.clrProt, strb.idOn, strb.idOff, strb.erase}));

  // R2: an open window suppresses all decoding
  a_r2_win_no_decode: assert property (@(posedge clk) disable iff (!rstN)
    (winOpen && wrValid) |=> state == S_IDLE);

endmodule

// File: rtl/usd_dpath.sv
module usd_dpath
  import usd_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              CMP_W    = 15,
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h004F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvInitN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pageDone,
  input  logic [ADDR_W-1:0] rdAddr,
  input  ctrlStrobeT        strb,
  output cmdMatchT          match,
  output logic              protOn,
  output logic              winOpen,
  output logic              idMode,
  output logic              dataWrOk,
  output logic              eraseStart,
  output logic              cmdDone,
  output logic              idHit,
  output logic [DATA_W-1:0] idData
);

  usd_match #(
    .ADDR_W(ADDR_W),
    .CMP_W (CMP_W),
    .DATA_W(DATA_W)
  ) match_i (
    .addr (wrAddr),
    .data (wrData),
    .match(match)
  );

  // persistent flag: only its own initialisation sets it unconditionally
  always_ff @(posedge clk or negedge nvInitN) begin
    if (!nvInitN)                   protOn <= 1'b1;
    else if (rstN && strb.setProt)  protOn <= 1'b1;
    else if (rstN && strb.clrProt)  protOn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen    <= 1'b0;
      idMode     <= 1'b0;
      dataWrOk   <= 1'b0;
      eraseStart <= 1'b0;
      cmdDone    <= 1'b0;
    end else begin
      if (strb.openWin)   winOpen <= 1'b1;
      else if (pageDone)  winOpen <= 1'b0;
      if (strb.idOn)      idMode  <= 1'b1;
      else if (strb.idOff) idMode <= 1'b0;
      dataWrOk   <= strb.dataOk;
      eraseStart <= strb.erase;
      cmdDone    <= strb.done;
    end
  end

  logic rdWord0;
  logic rdWord1;
  assign rdWord0 = rdAddr == ADDR_W'(0);
  assign rdWord1 = rdAddr == ADDR_W'(1);

  always_comb begin
    idHit  = idMode && (rdWord0 || rdWord1);
    idData = '0;
    if (idMode && rdWord0)      idData = MFR_CODE;
    else if (idMode && rdWord1) idData = DEV_CODE;
  end

  // R11: the flag falls only after a clear command
  a_r11_prot_fall: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    $fell(protOn) |-> $past(strb.clrProt));

  // R3: page data only when unprotected or inside a window
  a_r3_data_gate: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    dataWrOk |-> ($past(!protOn) || $past(winOpen)));

  // R9: completion pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  // R5: erase start is always a completed command
  a_r5_erase_done: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> cmdDone);

  // R2: window opens together with protection
  a_r2_win_prot: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    $rose(winOpen) |-> protOn);

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import usd_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              CMP_W    = 15,
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00DA,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h004F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvInitN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              pageDone,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              protectOn,
  output logic              pageWin,
  output logic              idMode,
  output logic              dataWrOk,
  output logic              eraseStart,
  output logic              cmdDone,
  output logic              idHit,
  output logic [DATA_W-1:0] idData
);

  cmdMatchT   match;
  ctrlStrobeT strb;

  usd_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrValid(wrValid),
    .busy   (busy),
    .winOpen(pageWin),
    .protOn (protectOn),
    .match  (match),
    .strb   (strb)
  );

  usd_dpath #(
    .ADDR_W  (ADDR_W),
    .CMP_W   (CMP_W),
    .DATA_W  (DATA_W),
    .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .nvInitN   (nvInitN),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .pageDone  (pageDone),
    .rdAddr    (rdAddr),
    .strb      (strb),
    .match     (match),
    .protOn    (protectOn),
    .winOpen   (pageWin),
    .idMode    (idMode),
    .dataWrOk  (dataWrOk),
    .eraseStart(eraseStart),
    .cmdDone   (cmdDone),
    .idHit     (idHit),
    .idData    (idData)
  );

endmodule

// File: tb/unlock_seq_decoder_tb_top.sv
`timescale 1ns/1ps
module unlock_seq_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nvInitN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        busy = 1'b0;
  logic        pageDone = 1'b0;
  logic [15:0] rdAddr = '0;
  logic        protectOn, pageWin, idMode, dataWrOk, eraseStart, cmdDone, idHit;
  logic [15:0] idData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  unlock_seq_decoder dut_i (
    .clk(clk), .rstN(rstN), .nvInitN(nvInitN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .pageDone(pageDone),
    .rdAddr(rdAddr), .protectOn(protectOn), .pageWin(pageWin), .idMode(idMode),
    .dataWrOk(dataWrOk), .eraseStart(eraseStart), .cmdDone(cmdDone),
    .idHit(idHit), .idData(idData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic endPage();
    @(negedge clk); pageDone = 1'b1;
    @(negedge clk); pageDone = 1'b0;
  endtask

  task automatic longPrefix();
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'h8080);
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555);
  endtask

  task automatic protSeq(input logic [15:0] hi);
    wr(16'h5555 | hi, 16'hAAAA); wr(16'h2AAA | hi, 16'h5555); wr(16'h5555 | hi, 16'hA0A0);
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nvInitN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 protectOn", protectOn, 1);
    chk("R12 idMode", idMode, 0);
    chk("R12 pageWin", pageWin, 0);
    chk("R12 pulses", {dataWrOk, eraseStart, cmdDone}, 0);
    chk("R12 idHit", idHit, 0);

    // R3 protected plain write refused
    wr(16'h0100, 16'h1234);
    chk("R3 protected plain write", dataWrOk, 0);

    // R2 protected write opens window
    protSeq(16'h0000);
    chk("R9 done after prot seq", cmdDone, 1);
    chk("R2 window open", pageWin, 1);
    chk("R2 protect set", protectOn, 1);
    wr(16'h0180, 16'hBEEF);
    chk("R2 page data accepted", dataWrOk, 1);
    chk("R9 done single", cmdDone, 0);
    wr(16'h5555, 16'hAAAA);
    chk("R2 command word as data", dataWrOk, 1);
    wr(16'h2AAA, 16'h5555);
    wr(16'h5555, 16'h2020);
    chk("R2 no decode in window", cmdDone, 0);
    chk("R2 protect kept in window", protectOn, 1);
    endPage();
    chk("R2 window closed", pageWin, 0);
    wr(16'h0101, 16'h0001);
    chk("R3 refused after window", dataWrOk, 0);

    // R4 disable
    longPrefix(); wr(16'h5555, 16'h2020);
    chk("R9 done after disable", cmdDone, 1);
    chk("R4 protect cleared", protectOn, 0);
    wr(16'h0200, 16'h7777);
    chk("R3 unprotected write accepted", dataWrOk, 1);

    // R11 rstN leaves protect flag
    pulseReset();
    chk("R11 protect kept clear over rstN", protectOn, 0);
    protSeq(16'h0000);
    chk("R2 protect set from clear", protectOn, 1);
    endPage();

    // R5 erase
    longPrefix(); wr(16'h5555, 16'h1010);
    chk("R5 eraseStart", eraseStart, 1);
    chk("R9 done with erase", cmdDone, 1);
    chk("R5 protect unchanged", protectOn, 1);
    @(negedge clk);
    chk("R5 erase single pulse", eraseStart, 0);

    // R10 busy
    busy = 1'b1;
    protSeq(16'h0000);
    chk("R10 busy blocks start", cmdDone, 0);
    chk("R10 busy no window", pageWin, 0);
    busy = 1'b0;
    wr(16'h5555, 16'hAAAA);
    busy = 1'b1;
    wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'hA0A0);
    chk("R10 in-progress completes", cmdDone, 1);
    busy = 1'b0;
    endPage();

    // R6 long ID entry, R7 reads
    longPrefix(); wr(16'h5555, 16'h6060);
    chk("R6 long entry", idMode, 1);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); rdAddr = 16'(a); #1;
      chk("R7 idHit sweep", idHit, (a < 2) ? 1 : 0);
      chk("R7 idData sweep", idData, (a == 0) ? 32'h00DA : (a == 1) ? 32'h004F : 0);
    end
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0);
    chk("R6 exit", idMode, 0);
    for (int a = 0; a < 2; a++) begin
      @(negedge clk); rdAddr = 16'(a); #1;
      chk("R7 no hit out of mode", {idHit, idData}, 0);
    end
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    chk("R6 short entry", idMode, 1);
    @(negedge clk); rdAddr = 16'h0001; #1;
    chk("R7 device code", idData, 32'h004F);
    pulseReset();
    chk("R11 idMode cleared by rstN", idMode, 0);
    chk("R11 protect kept set over rstN", protectOn, 1);

    // R8 restart on mismatch
    wr(16'h5555, 16'hAAAA);
    protSeq(16'h0000);
    chk("R8 repeated first step restarts", cmdDone, 1);
    endPage();
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    chk("R8 byte code in full track", idMode, 0);
    chk("R8 no done on mixed track", cmdDone, 0);
    for (int b = 0; b < 16; b++) begin
      wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555);
      wr(16'h5555, 16'hA0A0 ^ (16'h1 << b));
      chk("R8 data bit flip aborts", {cmdDone, pageWin, dataWrOk}, 0);
    end

    // R1 address bit sweep on last step
    for (int b = 0; b < 16; b++) begin
      wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555);
      wr(16'h5555 ^ (16'h1 << b), 16'hA0A0);
      chk("R1 address bit sweep", cmdDone, (b == 15) ? 1 : 0);
      if (pageWin) endPage();
    end
    protSeq(16'h8000);
    chk("R1 high bit on all steps", cmdDone, 1);
    endPage();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule